// File: doc/BRIEF.md
# Sampling ADC Control Sequencer

This block is the digital control logic of a 12-bit successive-approximation converter that connects to a processor through a byte-wide parallel port. The processor writes an 8-bit control byte, and the block latches it on the rising edge of a write strobe that is qualified by an active-low chip select. From that byte the block decodes the power state, the clock-source selection, the acquisition mode, the input mode (single-ended or pseudo-differential), the polarity (unipolar or bipolar) and the channel address. It then steps through an acquisition phase and a 13-cycle conversion phase.

The conversion datapath is a behavioural successive-approximation register. On each step it presents a trial code on `dac_code` and reads back a comparator bit. When the result is ready, an active-low completion flag falls. The processor then reads the 12-bit result as two bytes, using a high-byte select. All port strobes are sampled on the rising edge of the conversion clock, and every cycle count below is counted in that clock. The internal-clock mode runs from the same clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, `int_n` is 1, `ext_clk_sel` is 1, `power_down`, `full_shutdown`, `sample_hold`, `tracking` and `dout_oe` are 0.
- R2: A write is taken on the first clock edge that sees `wr_n` high after seeing it low with `cs_n` low. The byte fields are: bits 7:6 power code, bit 5 external-acquisition flag, bit 4 single-ended flag, bit 3 unipolar flag, bits 2:0 channel address.
- R3: A write with a normal power code (bit 7 = 1) and bit 5 = 0 starts an acquisition of 3 cycles, then a conversion of 13 cycles (`sample_hold` high). `int_n` falls on the 16th clock edge after the write edge.
- R4: A write with bit 5 = 1 starts tracking of unbounded length (`tracking` high, no conversion). The next write with bit 5 = 0 starts the conversion at once, and `int_n` falls on the 13th edge after that write.
- R5: If the channel address of the closing write differs from the address of the opening write, `conv_corrupt` is 1 for that conversion. It is 0 when the two addresses match.
- R6: The conversion resolves one bit per cycle, MSB first. On the first conversion cycle `dac_code` is the MSB alone. A trial bit is kept when `cmp_in` is 1, so the code converges to the level that the comparator reports.
- R7: `int_n` returns to 1 on the edge after a read falling edge (`rd_n` 1 to 0 with `cs_n` low), and on the edge after any accepted write.
- R8: A write accepted during a conversion aborts it. No completion is flagged for the aborted conversion, and the new command is timed from its own write edge.
- R9: With `hben` = 0, `dout` carries result bits 7:0. With `hben` = 1, `dout[3:0]` carries bits 11:8, and `dout[7:4]` is 0 in unipolar mode (bit 3 = 1) or repeats bit 11 in bipolar mode (bit 3 = 0). `dout_oe` is 1 only while `cs_n` and `rd_n` are both low.
- R10: In unipolar mode the result is straight binary. In bipolar mode the result is two's complement, which is the resolved code with its MSB inverted.
- R11: While `cs_n` is 1, write and read strobes are ignored and `dout_oe` is 0.
- R12: Power code 00 gives full shutdown and 01 gives standby. In both, no conversion runs and the clock source is kept. Code 10 selects normal operation with the internal clock (`ext_clk_sel` = 0), and code 11 selects normal operation with the external clock. The next write with a normal code leaves power-down.
- R13: Single-ended mode selects channel = address with the negative input on common (`neg_is_com` = 1). Pseudo-differential mode selects the pair {addr[1:0], addr[2]} as positive and {addr[1:0], ~addr[2]} as negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; rising edge latches the byte |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte select for reads |
| din | input | 8 | Control byte |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dout | output | 8 | Read data byte |
| dout_oe | output | 1 | Bus drive enable (0 = high impedance) |
| int_n | output | 1 | Result-ready flag, active low |
| dac_code | output | 12 | Trial code for the comparator, 0 outside conversion |
| sample_hold | output | 1 | High while converting (hold phase) |
| tracking | output | 1 | High during acquisition |
| ext_clk_sel | output | 1 | Clock source selection, 1 = external |
| power_down | output | 1 | Standby or shutdown active |
| full_shutdown | output | 1 | Full shutdown active |
| mux_pos | output | 3 | Positive input channel |
| mux_neg | output | 3 | Negative input channel in pseudo-differential mode |
| neg_is_com | output | 1 | Negative input taken from common |
| conv_corrupt | output | 1 | Address changed between the two writes of an external acquisition |

## Verification
On every cycle the assertions check the following:
- a conversion that completes has held `sample_hold` for exactly the conversion length;
- an accepted write always leaves `int_n` high;
- no conversion runs in power-down;
- the first trial code is the lone MSB;
- the high-byte bus never carries anything but zero or a copy of bit 11.

Only the directed scenarios can show the rest: the exact edge on which `int_n` falls in each acquisition mode, the converged result values and their byte split, the abort of a running conversion, the address-mismatch flag, and that strobes with chip select high leave every output untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CTRL_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ_INT,
        ST_ACQ_EXT,
        ST_CONV,
        ST_DOWN
    } seq_state_t;

    // Control byte, MSB first: power code, ext-acq, single-ended, unipolar, address
    typedef struct packed {
        logic [1:0]        pwr;
        logic              acq_ext;
        logic              single;
        logic              unipolar;
        logic [ADDR_W-1:0] addr;
    } ctrl_byte_t;

endpackage

// File: rtl/adc_strobe_edge.sv
module adc_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_rise,
    output logic rd_fall
);
    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } edge_regs_t;

    edge_regs_t e_d, e_q;

    always_comb begin
        e_d.wr_prev = wr_n;
        e_d.rd_prev = rd_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '{wr_prev: 1'b1, rd_prev: 1'b1};
        end else begin
            e_q <= e_d;
        end
    end

    // Strobes count only while chip select is low
    assign wr_rise = !cs_n && !e_q.wr_prev && wr_n;
    assign rd_fall = !cs_n && e_q.rd_prev && !rd_n;
endmodule

// File: rtl/adc_ctrl_decode.sv
module adc_ctrl_decode
    import adc_seq_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_byte,
    output ctrl_byte_t        fields,
    output logic [ADDR_W-1:0] mux_pos,
    output logic [ADDR_W-1:0] mux_neg,
    output logic              neg_is_com
);
    always_comb begin
        fields     = ctrl_byte_t'(ctrl_byte);
        neg_is_com = fields.single;
        if (fields.single) begin
            mux_pos = fields.addr;
            mux_neg = '0;
        end else begin
            // Pair index in the low address bits, swap of polarity in the top bit
            mux_pos = {fields.addr[ADDR_W-2:0],  fields.addr[ADDR_W-1]};
            mux_neg = {fields.addr[ADDR_W-2:0], ~fields.addr[ADDR_W-1]};
        end
    end
endmodule

// File: rtl/adc_bus_mux.sv
module adc_bus_mux #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             bipolar,
    input  logic             hben,
    output logic [BUS_W-1:0] data
);
    localparam int HI_W = RES_W - BUS_W;

    logic [BUS_W-1:0] hi_byte;

    generate
        for (genvar i = 0; i < BUS_W; i++) begin : g_hi
            if (i < HI_W) begin : g_bit
                assign hi_byte[i] = result[BUS_W + i];
            end else begin : g_ext
                assign hi_byte[i] = bipolar & result[RES_W-1];
            end
        end
    endgenerate

    assign data = hben ? hi_byte : result[BUS_W-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int BUS_W       = 8,
    parameter int ACQ_CYCLES  = 3,
    parameter int CONV_CYCLES = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic [7:0]       din,
    input  logic             cmp_in,
    output logic [BUS_W-1:0] dout,
    output logic             dout_oe,
    output logic             int_n,
    output logic [RES_W-1:0] dac_code,
    output logic             sample_hold,
    output logic             tracking,
    output logic             ext_clk_sel,
    output logic             power_down,
    output logic             full_shutdown,
    output logic [2:0]       mux_pos,
    output logic [2:0]       mux_neg,
    output logic             neg_is_com,
    output logic             conv_corrupt
);
    localparam int CNT_MAX = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] RES_STEPS = CNT_W'(RES_W);
    localparam logic [RES_W-1:0] MSB_MASK  = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        seq_state_t        state;
        logic [CNT_W-1:0]  cnt;
        logic [RES_W-1:0]  sar;
        logic [RES_W-1:0]  result;
        logic              res_bip;
        logic [CTRL_W-1:0] ctrl;
        logic              clk_ext;
        logic              int_n;
        logic              corrupt;
        logic              pd_full;
    } seq_regs_t;

    seq_regs_t  r_d, r_q;
    logic       wr_rise, rd_fall;
    ctrl_byte_t cur_f, new_f;
    logic [RES_W-1:0] trial;

    adc_strobe_edge i_edge (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .wr_rise (wr_rise),
        .rd_fall (rd_fall)
    );

    adc_ctrl_decode i_decode (
        .ctrl_byte  (r_q.ctrl),
        .fields     (cur_f),
        .mux_pos    (mux_pos),
        .mux_neg    (mux_neg),
        .neg_is_com (neg_is_com)
    );

    adc_bus_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) i_bus (
        .result  (r_q.result),
        .bipolar (r_q.res_bip),
        .hben    (hben),
        .data    (dout)
    );

    assign new_f = ctrl_byte_t'(din);

    // Trial code: current partial result with the bit under test set
    always_comb begin
        trial = r_q.sar;
        if (r_q.cnt < RES_STEPS) begin
            trial = r_q.sar | (MSB_MASK >> r_q.cnt);
        end
    end

    always_comb begin
        r_d = r_q;
        if (rd_fall) begin
            r_d.int_n = 1'b1;
        end
        if (wr_rise) begin
            r_d.ctrl    = din;
            r_d.int_n   = 1'b1;
            r_d.corrupt = 1'b0;
            if (new_f.pwr[1]) begin
                r_d.clk_ext = new_f.pwr[0];
                r_d.pd_full = 1'b0;
                r_d.cnt     = '0;
                r_d.sar     = '0;
                if (new_f.acq_ext) begin
                    r_d.state = ST_ACQ_EXT;
                end else if (r_q.state == ST_ACQ_EXT) begin
                    r_d.state   = ST_CONV;
                    r_d.corrupt = (new_f.addr != cur_f.addr);
                end else begin
                    r_d.state = ST_ACQ_INT;
                end
            end else begin
                r_d.state   = ST_DOWN;
                r_d.pd_full = !new_f.pwr[0];
            end
        end else begin
            unique case (r_q.state)
                ST_ACQ_INT: begin
                    if (r_q.cnt == ACQ_LAST) begin
                        r_d.state = ST_CONV;
                        r_d.cnt   = '0;
                        r_d.sar   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (r_q.cnt < RES_STEPS && cmp_in) begin
                        r_d.sar = trial;
                    end
                    if (r_q.cnt == CONV_LAST) begin
                        r_d.state   = ST_IDLE;
                        r_d.res_bip = !cur_f.unipolar;
                        r_d.result  = cur_f.unipolar ? r_q.sar : (r_q.sar ^ MSB_MASK);
                        r_d.int_n   = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.clk_ext <= 1'b1;
            r_q.int_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_oe       = !cs_n && !rd_n;
    assign int_n         = r_q.int_n;
    assign sample_hold   = (r_q.state == ST_CONV);
    assign tracking      = (r_q.state == ST_ACQ_INT) || (r_q.state == ST_ACQ_EXT);
    assign dac_code      = sample_hold ? trial : '0;
    assign ext_clk_sel   = r_q.clk_ext;
    assign power_down    = (r_q.state == ST_DOWN);
    assign full_shutdown = power_down && r_q.pd_full;
    assign conv_corrupt  = r_q.corrupt;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int RES_W       = 12,
    parameter int BUS_W       = 8,
    parameter int CONV_CYCLES = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_rise,
    input logic             int_n,
    input logic             sample_hold,
    input logic             power_down,
    input logic [RES_W-1:0] dac_code,
    input logic [BUS_W-1:0] dout,
    input logic             dout_oe,
    input logic             hben
);
    localparam int HI_W = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - HI_W;

    logic [15:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_run <= '0;
        end else if (sample_hold) begin
            if (hold_run != 16'hFFFF) hold_run <= hold_run + 16'd1;
        end else begin
            hold_run <= '0;
        end
    end

    // R3 / R4: a completed conversion always spans the full conversion length
    p_conv_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> (hold_run == 16'(CONV_CYCLES)));

    // R7: an accepted write leaves the ready flag inactive
    p_int_high_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> int_n);

    // R12: power-down never coexists with a conversion
    p_no_conv_in_pd_r12: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !sample_hold);

    // R6: first trial of every conversion tests the MSB alone
    p_msb_first_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_hold) |-> (dac_code == {1'b1, {(RES_W-1){1'b0}}}));

    // R9: upper part of the high byte is zero or a copy of the result MSB
    p_hi_pad_r9: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && hben) |->
            ((dout[BUS_W-1:HI_W] == '0) || (dout[BUS_W-1:HI_W] == {PAD_W{dout[HI_W-1]}})));
endmodule

bind adc_seq_ctrl adc_seq_checker #(
    .RES_W       (RES_W),
    .BUS_W       (BUS_W),
    .CONV_CYCLES (CONV_CYCLES)
) i_seq_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_rise     (wr_rise),
    .int_n       (int_n),
    .sample_hold (sample_hold),
    .power_down  (power_down),
    .dac_code    (dac_code),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .hben        (hben)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        cmp_in;
    logic [7:0]  dout;
    logic        dout_oe, int_n, sample_hold, tracking, ext_clk_sel;
    logic        power_down, full_shutdown, neg_is_com, conv_corrupt;
    logic [11:0] dac_code;
    logic [2:0]  mux_pos, mux_neg;

    int pass_cnt = 0;
    int fail_cnt = 0;
    logic [11:0] level = 12'd0;   // analog level in offset-binary LSBs
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Comparator model: keep the trial bit when the level reaches the trial code
    assign cmp_in = (level >= dac_code);

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .hben(hben),
        .din(din), .cmp_in(cmp_in), .dout(dout), .dout_oe(dout_oe), .int_n(int_n),
        .dac_code(dac_code), .sample_hold(sample_hold), .tracking(tracking),
        .ext_clk_sel(ext_clk_sel), .power_down(power_down),
        .full_shutdown(full_shutdown), .mux_pos(mux_pos), .mux_neg(mux_neg),
        .neg_is_com(neg_is_com), .conv_corrupt(conv_corrupt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); cs_n = 1'b0; din = b; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic read_byte(input logic hb, output logic [7:0] v, output logic oe);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; hben = hb;
        #1 v = dout; oe = dout_oe;
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    endtask

    // Counts clock edges after the write edge until int_n is seen low
    task automatic wait_done(output int n);
        n = 0;
        while (int_n && n < 100) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic t_reset;
        check_eq("R1 int_n", int_n, 1);
        check_eq("R1 ext_clk_sel", ext_clk_sel, 1);
        check_eq("R1 power_down", power_down, 0);
        check_eq("R1 busy", {sample_hold, tracking, dout_oe}, 0);
    endtask

    task automatic t_internal_unipolar;
        int n; logic [7:0] v; logic oe;
        level = 12'hA5C;
        write_byte(8'hD8);   // R2: ext clock, internal acq, single, unipolar, ch0
        check_eq("R3 tracking after write", tracking, 1);
        wait_done(n);
        check_eq("R3 cycles to int_n", n, 16);
        read_byte(1'b0, v, oe);
        check_eq("R6 R10 low byte", v, 8'h5C);
        check_eq("R9 dout_oe on read", oe, 1);
        check_eq("R7 int_n after read", int_n, 1);
        read_byte(1'b1, v, oe);
        check_eq("R9 unipolar high byte", v, 8'h0A);
    endtask

    task automatic t_bipolar;
        int n; logic [7:0] v; logic oe;
        level = 12'(2048 - 300);   // -300 in offset binary
        write_byte(8'hD0);
        wait_done(n);
        check_eq("R3 bipolar cycles", n, 16);
        read_byte(1'b0, v, oe);
        check_eq("R10 bipolar low byte", v, 8'hD4);
        read_byte(1'b1, v, oe);
        check_eq("R9 R10 sign extended high byte", v, 8'hFE);
        level = 12'(2048 + 291);   // +0x123
        write_byte(8'hD0);
        wait_done(n);
        read_byte(1'b1, v, oe);
        check_eq("R9 bipolar positive high byte", v, 8'h01);
        read_byte(1'b0, v, oe);
        check_eq("R10 bipolar positive low byte", v, 8'h23);
    endtask

    task automatic t_external_acq;
        int n; logic [7:0] v; logic oe;
        level = 12'h3C1;
        write_byte(8'hF8);   // external acquisition opens
        repeat (30) @(negedge clk);
        check_eq("R4 still tracking", {tracking, sample_hold}, 2'b10);
        check_eq("R7 int_n high while tracking", int_n, 1);
        write_byte(8'hD8);   // closes, same address
        wait_done(n);
        check_eq("R4 cycles to int_n", n, 13);
        check_eq("R5 matching address", conv_corrupt, 0);
        read_byte(1'b0, v, oe);
        check_eq("R4 result low byte", v, 8'hC1);
        write_byte(8'hF8);
        check_eq("R7 write clears int_n", int_n, 1);
        write_byte(8'hD9);   // different address
        check_eq("R5 mismatched address", conv_corrupt, 1);
        wait_done(n);
        check_eq("R4 mismatch still converts", n, 13);
    endtask

    task automatic t_abort;
        int n; bit early; logic [7:0] v; logic oe;
        level = 12'd100;
        write_byte(8'hD8);
        repeat (8) @(negedge clk);
        check_eq("R8 converting before abort", sample_hold, 1);
        level = 12'd3000;
        write_byte(8'hD8);
        early = 1'b0;
        wait_done(n);
        check_eq("R8 new command timing", n, 16);
        read_byte(1'b0, v, oe);
        check_eq("R8 result of new command", v, 8'hB8);
        read_byte(1'b1, v, oe);
        check_eq("R8 result high byte", v, 8'h0B);
    endtask

    task automatic t_chip_select;
        int n; bit moved; logic [7:0] v; logic oe;
        level = 12'd7;
        write_byte(8'hD8);
        wait_done(n);
        // strobes with chip select high
        @(negedge clk); din = 8'h18; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        moved = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sample_hold || tracking || power_down) moved = 1'b1;
        end
        check_eq("R11 write ignored", moved, 0);
        check_eq("R11 int_n kept after ignored write", int_n, 0);
        @(negedge clk); rd_n = 1'b0;
        #1 oe = dout_oe;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk);
        check_eq("R11 bus disabled", oe, 0);
        check_eq("R11 read ignored", int_n, 0);
        read_byte(1'b0, v, oe);
        check_eq("R11 result intact", v, 8'h07);
    endtask

    task automatic t_power;
        int n; bit moved;
        write_byte(8'h18);   // full shutdown
        check_eq("R12 shutdown", {power_down, full_shutdown}, 2'b11);
        moved = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sample_hold || tracking || !int_n) moved = 1'b1;
        end
        check_eq("R12 no conversion in shutdown", moved, 0);
        check_eq("R12 clock kept", ext_clk_sel, 1);
        level = 12'd55;
        write_byte(8'h98);   // normal, internal clock
        check_eq("R12 leaves power-down", power_down, 0);
        check_eq("R12 internal clock", ext_clk_sel, 0);
        wait_done(n);
        check_eq("R12 converts after wake", n, 16);
        write_byte(8'h58);   // standby
        check_eq("R12 standby", {power_down, full_shutdown}, 2'b10);
        check_eq("R12 clock kept in standby", ext_clk_sel, 0);
        write_byte(8'hD8);
        check_eq("R12 external clock", ext_clk_sel, 1);
        wait_done(n);
    endtask

    task automatic t_channels;
        write_byte(8'hDD);   // single-ended, address 5
        check_eq("R13 single pos", mux_pos, 5);
        check_eq("R13 single com", neg_is_com, 1);
        write_byte(8'hCC);   // pseudo-differential, address 4
        check_eq("R13 diff 4", {neg_is_com, mux_pos, mux_neg}, {1'b0, 3'd1, 3'd0});
        write_byte(8'hCB);   // pseudo-differential, address 3
        check_eq("R13 diff 3", {neg_is_com, mux_pos, mux_neg}, {1'b0, 3'd6, 3'd7});
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_internal_unipolar();
        t_bipolar();
        t_external_acq();
        t_abort();
        t_chip_select();
        t_power();
        t_channels();
        done = 1'b1;
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end
endmodule